// File: doc/BRIEF.md
# Warp Formation Unit

This unit accepts the shape of one thread block, given as up to three sizes, and walks through every thread of the block in linear order. The x coordinate counts fastest, then y, then z. The threads are grouped into warps of consecutive thread numbers. For every lane of every warp, the unit presents one output beat that carries:

- the warp number and the lane number;
- the warp's active-lane mask;
- the lane's (x, y, z) position inside the block.

One beat is presented per cycle, under a valid/ready pair.

A scheduler loads a block shape with a single-cycle start strobe while the unit is idle. It then drains the lane beats at whatever rate it can accept them. A one-cycle completion pulse follows the last beat.

A shape that has a zero size on any axis is refused. A shape holding more threads than the per-block cap is also refused. In either case the unit raises a one-cycle error pulse and emits nothing. Unused axes are given a size of one.

Top module: `warp_former`

## Requirements
- R1: While rst_n is low, lane_valid, busy, done and err are all low, including when reset arrives in the middle of a block.
- R2: For a block of size (Dx, Dy, Dz), the beat with thread number t = warp_idx*32 + lane_idx carries x = t mod Dx, y = (t / Dx) mod Dy and z = t / (Dx*Dy), so that t = x + y*Dx + z*Dx*Dy.
- R3: Beats leave in rising thread-number order. warp_idx = t / 32 and lane_idx = t mod 32. Every warp has all 32 lane beats, and ceil(N/32) warps are emitted for N = Dx*Dy*Dz.
- R4: Bit i of lane_mask is 1 exactly when warp_idx*32 + i < N. The mask holds the same value on every beat of a warp.
- R5: A beat whose thread number is N or more (a padding lane) shows x = y = z = 0.
- R6: While lane_valid is high and out_ready is low, every output beat field holds its value into the next cycle.
- R7: done is high for exactly one cycle, in the cycle after the final beat is accepted. busy is low in the cycle after that.
- R8: A start with any size of 0, or with Dx*Dy*Dz above 1024, gives err high for one cycle in the cycle after the start. No beat is emitted, and busy is low in the cycle after err.
- R9: The unit takes start only when busy is low. While busy is high, start and the dimension inputs have no effect on the beats.
- R10: A block of exactly 1024 threads is accepted. It produces 32 warps whose masks are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load a block shape (taken only when busy is low) |
| dim_x | input | 11 | Block size along x |
| dim_y | input | 11 | Block size along y (1 when unused) |
| dim_z | input | 11 | Block size along z (1 when unused) |
| out_ready | input | 1 | Consumer accepts the current beat |
| busy | output | 1 | A block is in progress or finishing |
| err | output | 1 | One-cycle pulse: shape refused |
| done | output | 1 | One-cycle pulse: last beat accepted |
| lane_valid | output | 1 | A lane beat is presented |
| warp_idx | output | 5 | Warp number of the beat |
| lane_idx | output | 5 | Lane number within the warp |
| lane_mask | output | 32 | Active lanes of the current warp |
| crd_x | output | 10 | Thread x coordinate |
| crd_y | output | 10 | Thread y coordinate |
| crd_z | output | 10 | Thread z coordinate |

## Verification
The bench targets the following corner cases, and names the failure each one would expose:

- Shapes with partial last warps, a single thread, exact warp multiples, z-only shapes and the full 1024-thread shape. These would expose a mask comparison that is off by one, or padding lanes that leak the walker's stale coordinates.
- Irregular back-pressure. This shows whether a coordinate counter advances on a stalled beat, which would skew every later coordinate, or whether the walker carries at the wrong bound when an axis size is 1.
- Refused shapes: a zero axis, a product just over the cap, and the largest single axis plus one. A design with a narrow product or a missing zero check would start emitting beats instead of pulsing err.
- A second start, with different sizes, in the middle of a block. A design that reloaded would corrupt the running block.

// File: rtl/wf_pkg.sv
package wf_pkg;

  // Sequencer phases of the warp formation unit.
  typedef enum logic [1:0] {
    WF_IDLE = 2'd0,
    WF_RUN  = 2'd1,
    WF_FIN  = 2'd2,
    WF_ERR  = 2'd3
  } wf_state_e;

endpackage

// File: rtl/wf_cfg_check.sv
// Legality check of a block shape and derivation of thread and warp totals.
module wf_cfg_check #(
  parameter int MAX_THREADS = 1024,
  parameter int WARP_SIZE   = 32,
  parameter int DIM_W       = 11,
  parameter int WCNT_W      = 6
) (
  input  logic [DIM_W-1:0]  dim_x,
  input  logic [DIM_W-1:0]  dim_y,
  input  logic [DIM_W-1:0]  dim_z,
  output logic              cfg_bad,
  output logic [DIM_W-1:0]  thread_total,
  output logic [WCNT_W-1:0] warp_total
);

  localparam int PROD_W = 3 * DIM_W;
  localparam int LANE_W = $clog2(WARP_SIZE);

  logic [PROD_W-1:0] prod;
  logic              any_zero;
  logic [DIM_W:0]    rounded;

  always_comb begin
    prod     = PROD_W'(dim_x) * PROD_W'(dim_y) * PROD_W'(dim_z);
    any_zero = (dim_x == '0) || (dim_y == '0) || (dim_z == '0);
    cfg_bad  = any_zero || (prod > PROD_W'(MAX_THREADS));
    // Only meaningful when the shape is legal; then it fits in DIM_W bits.
    thread_total = prod[DIM_W-1:0];
    rounded      = {1'b0, thread_total} + (DIM_W+1)'(WARP_SIZE - 1);
    warp_total   = WCNT_W'(rounded >> LANE_W);
  end

endmodule

// File: rtl/wf_coord_walk.sv
// Chain of wrapping axis counters; axis 0 counts fastest.
module wf_coord_walk #(
  parameter int NDIM  = 3,
  parameter int DIM_W = 11,
  parameter int CRD_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        step,
  input  logic [NDIM-1:0][DIM_W-1:0]  lim,
  output logic [NDIM-1:0][CRD_W-1:0]  crd
);

  logic [NDIM-1:0] carry;

  assign carry[0] = step;

  for (genvar g = 0; g < NDIM; g++) begin : g_axis
    logic [CRD_W-1:0] cnt_q;
    logic [CRD_W-1:0] cnt_d;
    logic             at_end;
    logic             cnt_en;

    assign at_end = (DIM_W'(cnt_q) == (lim[g] - DIM_W'(1)));

    if (g < NDIM - 1) begin : g_carry
      assign carry[g+1] = carry[g] & at_end;
    end

    always_comb begin
      cnt_d = cnt_q;
      if (clear) begin
        cnt_d = '0;
      end else if (carry[g]) begin
        cnt_d = at_end ? '0 : cnt_q + CRD_W'(1);
      end
    end

    assign cnt_en = clear | carry[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end

    assign crd[g] = cnt_q;
  end

endmodule

// File: rtl/wf_lane_seq.sv
// Phase machine plus lane and warp counters.
module wf_lane_seq
  import wf_pkg::*;
#(
  parameter int LANE_W = 5,
  parameter int WARP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_bad,
  input  logic [WARP_W-1:0] warp_last,
  input  logic              out_ready,
  output wf_state_e         state,
  output logic [LANE_W-1:0] lane,
  output logic [WARP_W-1:0] warp,
  output logic              accept
);

  wf_state_e         state_q, state_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [WARP_W-1:0] warp_q, warp_d;
  logic              cnt_en;

  assign accept = (state_q == WF_RUN) && out_ready;

  always_comb begin
    state_d = state_q;
    lane_d  = lane_q;
    warp_d  = warp_q;
    unique case (state_q)
      WF_IDLE: begin
        if (start) begin
          state_d = cfg_bad ? WF_ERR : WF_RUN;
          lane_d  = '0;
          warp_d  = '0;
        end
      end
      WF_RUN: begin
        if (accept) begin
          if (lane_q == '1) begin
            lane_d = '0;
            if (warp_q == warp_last) begin
              state_d = WF_FIN;
            end else begin
              warp_d = warp_q + WARP_W'(1);
            end
          end else begin
            lane_d = lane_q + LANE_W'(1);
          end
        end
      end
      WF_FIN:  state_d = WF_IDLE;
      WF_ERR:  state_d = WF_IDLE;
      default: state_d = WF_IDLE;
    endcase
  end

  assign cnt_en = ((state_q == WF_IDLE) && start) || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WF_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      warp_q <= '0;
    end else if (cnt_en) begin
      lane_q <= lane_d;
      warp_q <= warp_d;
    end
  end

  assign state = state_q;
  assign lane  = lane_q;
  assign warp  = warp_q;

endmodule

// File: rtl/warp_former.sv
// Thread block warp formation unit: enumerates threads x-fastest into warps.
module warp_former
  import wf_pkg::*;
#(
  parameter  int MAX_THREADS = 1024,
  parameter  int WARP_SIZE   = 32,
  localparam int DIM_W  = $clog2(MAX_THREADS) + 1,
  localparam int CRD_W  = $clog2(MAX_THREADS),
  localparam int LANE_W = $clog2(WARP_SIZE),
  localparam int WARP_W = $clog2(MAX_THREADS / WARP_SIZE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DIM_W-1:0]     dim_x,
  input  logic [DIM_W-1:0]     dim_y,
  input  logic [DIM_W-1:0]     dim_z,
  input  logic                 out_ready,
  output logic                 busy,
  output logic                 err,
  output logic                 done,
  output logic                 lane_valid,
  output logic [WARP_W-1:0]    warp_idx,
  output logic [LANE_W-1:0]    lane_idx,
  output logic [WARP_SIZE-1:0] lane_mask,
  output logic [CRD_W-1:0]     crd_x,
  output logic [CRD_W-1:0]     crd_y,
  output logic [CRD_W-1:0]     crd_z
);

  localparam int NDIM   = 3;
  localparam int WCNT_W = WARP_W + 1;
  localparam int TID_W  = WARP_W + LANE_W;

  wf_state_e                  state;
  logic                       cfg_bad;
  logic [DIM_W-1:0]           tot_in;
  logic [WCNT_W-1:0]          wtot_in;
  logic                       load;
  logic                       accept;
  logic [LANE_W-1:0]          lane;
  logic [WARP_W-1:0]          warp;
  logic [TID_W-1:0]           tid;
  logic                       live;
  logic [NDIM-1:0][CRD_W-1:0] crd;

  // Shape registers, loaded only by an accepted start.
  logic [DIM_W-1:0]           total_q, total_d;
  logic [WARP_W-1:0]          wlast_q, wlast_d;
  logic [NDIM-1:0][DIM_W-1:0] lim_q, lim_d;

  wf_cfg_check #(
    .MAX_THREADS (MAX_THREADS),
    .WARP_SIZE   (WARP_SIZE),
    .DIM_W       (DIM_W),
    .WCNT_W      (WCNT_W)
  ) u_cfg (
    .dim_x        (dim_x),
    .dim_y        (dim_y),
    .dim_z        (dim_z),
    .cfg_bad      (cfg_bad),
    .thread_total (tot_in),
    .warp_total   (wtot_in)
  );

  assign load = start && (state == WF_IDLE);

  always_comb begin
    total_d  = tot_in;
    wlast_d  = WARP_W'(wtot_in - WCNT_W'(1));
    lim_d[0] = dim_x;
    lim_d[1] = dim_y;
    lim_d[2] = dim_z;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      wlast_q <= '0;
      lim_q   <= '0;
    end else if (load) begin
      total_q <= total_d;
      wlast_q <= wlast_d;
      lim_q   <= lim_d;
    end
  end

  wf_lane_seq #(
    .LANE_W (LANE_W),
    .WARP_W (WARP_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_bad   (cfg_bad),
    .warp_last (wlast_q),
    .out_ready (out_ready),
    .state     (state),
    .lane      (lane),
    .warp      (warp),
    .accept    (accept)
  );

  assign tid  = {warp, lane};
  assign live = DIM_W'(tid) < total_q;

  wf_coord_walk #(
    .NDIM  (NDIM),
    .DIM_W (DIM_W),
    .CRD_W (CRD_W)
  ) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .step  (accept & live),
    .lim   (lim_q),
    .crd   (crd)
  );

  // One comparator per lane: a lane is active if its thread number is in range.
  for (genvar i = 0; i < WARP_SIZE; i++) begin : g_mask
    assign lane_mask[i] = DIM_W'({warp, LANE_W'(i)}) < total_q;
  end

  assign lane_valid = (state == WF_RUN);
  assign busy       = (state != WF_IDLE);
  assign done       = (state == WF_FIN);
  assign err        = (state == WF_ERR);
  assign warp_idx   = warp;
  assign lane_idx   = lane;
  assign crd_x      = live ? crd[0] : '0;
  assign crd_y      = live ? crd[1] : '0;
  assign crd_z      = live ? crd[2] : '0;

endmodule

// File: rtl/wf_checker.sv
// Temporal properties of the warp formation unit.
module wf_checker #(
  parameter int WARP_SIZE = 32,
  parameter int LANE_W    = 5,
  parameter int WARP_W    = 5,
  parameter int CRD_W     = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 err,
  input logic                 done,
  input logic                 lane_valid,
  input logic                 out_ready,
  input logic [WARP_W-1:0]    warp_idx,
  input logic [LANE_W-1:0]    lane_idx,
  input logic [WARP_SIZE-1:0] lane_mask,
  input logic [CRD_W-1:0]     crd_x,
  input logic [CRD_W-1:0]     crd_y,
  input logic [CRD_W-1:0]     crd_z
);

  assert_lane_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid && out_ready && (lane_idx != '1) |=>
      lane_valid && (lane_idx == $past(lane_idx) + LANE_W'(1)) &&
      (warp_idx == $past(warp_idx)));

  assert_mask_lane0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> lane_mask[0]);

  assert_mask_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid && $past(lane_valid) && (warp_idx == $past(warp_idx)) |->
      $stable(lane_mask));

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid && !lane_mask[lane_idx] |->
      (crd_x == '0) && (crd_y == '0) && (crd_z == '0));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid && !out_ready |=>
      lane_valid && $stable(lane_idx) && $stable(warp_idx) &&
      $stable(lane_mask) && $stable(crd_x) && $stable(crd_y) && $stable(crd_z));

  assert_done_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(lane_valid && out_ready && (lane_idx == '1)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start && !busy) && !lane_valid);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !busy && !lane_valid && !err);

endmodule

bind warp_former wf_checker #(
  .WARP_SIZE (WARP_SIZE),
  .LANE_W    (LANE_W),
  .WARP_W    (WARP_W),
  .CRD_W     (CRD_W)
) u_wf_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .err        (err),
  .done       (done),
  .lane_valid (lane_valid),
  .out_ready  (out_ready),
  .warp_idx   (warp_idx),
  .lane_idx   (lane_idx),
  .lane_mask  (lane_mask),
  .crd_x      (crd_x),
  .crd_y      (crd_y),
  .crd_z      (crd_z)
);

// File: tb/test_warp_former.sv
`timescale 1ns/1ps
module test_warp_former;

  localparam int MAXT = 1024;
  localparam int WS   = 32;
  localparam int DW   = 11;
  localparam int CW   = 10;
  localparam int LW   = 5;
  localparam int WW   = 5;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [DW-1:0] dim_x, dim_y, dim_z;
  logic          out_ready;
  logic          busy, err, done, lane_valid;
  logic [WW-1:0] warp_idx;
  logic [LW-1:0] lane_idx;
  logic [WS-1:0] lane_mask;
  logic [CW-1:0] crd_x, crd_y, crd_z;

  int n_chk;
  int n_bad;

  warp_former i_warp_former (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dim_x      (dim_x),
    .dim_y      (dim_y),
    .dim_z      (dim_z),
    .out_ready  (out_ready),
    .busy       (busy),
    .err        (err),
    .done       (done),
    .lane_valid (lane_valid),
    .warp_idx   (warp_idx),
    .lane_idx   (lane_idx),
    .lane_mask  (lane_mask),
    .crd_x      (crd_x),
    .crd_y      (crd_y),
    .crd_z      (crd_z)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Shape table: x, y, z sizes and whether the shape must be refused.
  localparam int NV = 14;
  localparam int VX[NV] = '{1, 32, 33, 5, 7, 4, 1, 1024, 8, 0, 32, 1025, 3, 3};
  localparam int VY[NV] = '{1, 1,  1,  3, 5, 4, 1, 1,    8, 4, 32, 1,    1, 1};
  localparam int VZ[NV] = '{1, 1,  1,  2, 3, 4, 32, 1,   16, 4, 2, 1,    0, 31};
  // Entries 7 and 8 are the full 1024-thread case (R10); 9..12 are refused (R8).
  localparam bit VE[NV] = '{0, 0,  0,  0, 0, 0, 0, 0,    0, 1, 1, 1,    1, 0};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one block shape. poke issues a second start with other sizes mid-block.
  task automatic run_block(input int dx, input int dy, input int dz,
                           input bit exp_err, input bit stall_en, input bit poke);
    int n, nl, t, cyc;
    bit rdy, prev_stall, poked;
    string rq;
    @(negedge clk);
    dim_x = DW'(dx); dim_y = DW'(dy); dim_z = DW'(dz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (exp_err) begin
      check(err == 1'b1, "R8", "err after refused start", 64'(err), 64'(1));
      check(lane_valid == 1'b0, "R8", "no beat on refusal", 64'(lane_valid), 64'(0));
      @(negedge clk);
      check(err == 1'b0 && busy == 1'b0 && lane_valid == 1'b0, "R8",
            "quiet after err", {61'(0), err, busy, lane_valid}, 64'(0));
      return;
    end
    n  = dx * dy * dz;
    nl = ((n + WS - 1) / WS) * WS;
    t = 0; cyc = 0; prev_stall = 1'b0; poked = 1'b0;
    while (t < nl && cyc < 20000) begin
      logic [WS-1:0] em;
      int ex, ey, ez;
      for (int i = 0; i < WS; i++) em[i] = ((t / WS) * WS + i) < n;
      if (t < n) begin
        ex = t % dx; ey = (t / dx) % dy; ez = t / (dx * dy);
      end else begin
        ex = 0; ey = 0; ez = 0;
      end
      rq = prev_stall ? "R6" : (poked ? "R9" : "R3");
      check(lane_valid == 1'b1, rq, "lane_valid", 64'(lane_valid), 64'(1));
      check(err == 1'b0, rq, "err during block", 64'(err), 64'(0));
      check(warp_idx == WW'(t / WS) && lane_idx == LW'(t % WS), rq, "warp/lane index",
            64'({warp_idx, lane_idx}), 64'(t));
      rq = prev_stall ? "R6" : (poked ? "R9" : "R4");
      check(lane_mask == em, rq, "lane_mask", 64'(lane_mask), 64'(em));
      rq = prev_stall ? "R6" : (poked ? "R9" : ((t < n) ? "R2" : "R5"));
      check(crd_x == CW'(ex) && crd_y == CW'(ey) && crd_z == CW'(ez), rq, "coords",
            {34'(0), crd_z, crd_y, crd_x}, {34'(0), CW'(ez), CW'(ey), CW'(ex)});
      rdy = stall_en ? (((cyc % 5) != 2) && ((cyc % 7) != 3)) : 1'b1;
      out_ready = rdy;
      if (poke && t == 3 && !poked) begin
        start = 1'b1;
        dim_x = DW'(2); dim_y = DW'(9); dim_z = DW'(1);
        poked = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (rdy) t++;
      prev_stall = !rdy;
      cyc++;
    end
    out_ready = 1'b1;
    if (n == MAXT) check(t == MAXT, "R10", "lanes accepted", 64'(t), 64'(MAXT));
    check(done == 1'b1 && lane_valid == 1'b0, "R7", "done after last beat",
          {62'(0), done, lane_valid}, 64'(2));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done single pulse",
          {62'(0), done, busy}, 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b1;
    dim_x = '0; dim_y = '0; dim_z = '0;
    repeat (3) @(negedge clk);
    check({busy, err, done, lane_valid} == 4'b0, "R1", "reset state",
          64'({busy, err, done, lane_valid}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, err, done, lane_valid} == 4'b0, "R1", "idle after reset",
          64'({busy, err, done, lane_valid}), 64'(0));

    for (int v = 0; v < NV; v++) begin
      run_block(VX[v], VY[v], VZ[v], VE[v], (v % 2) == 1, 1'b0);
    end

    // R9: mid-block restart with other sizes must be ignored.
    run_block(4, 4, 1, 1'b0, 1'b1, 1'b1);
    // R6 heavy stalling with a 3D shape.
    run_block(3, 2, 6, 1'b0, 1'b1, 1'b0);

    // R1: reset in the middle of a block.
    @(negedge clk);
    dim_x = DW'(8); dim_y = DW'(8); dim_z = DW'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check({busy, err, done, lane_valid} == 4'b0, "R1", "async reset mid-block",
          64'({busy, err, done, lane_valid}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, lane_valid} == 2'b0, "R1", "idle after mid-block reset",
          64'({busy, lane_valid}), 64'(0));
    // Unit must work normally after that reset.
    run_block(6, 1, 1, 1'b0, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule